// File: doc/BRIEF.md
# Programmable Vertical Display Timing Generator

This block produces the vertical blanking and vertical sync signals for a raster display controller. It counts scan lines from a one-cycle strobe that a horizontal timing unit issues once per line, and in interlaced mode from a second strobe that the same unit issues at mid-line. Three timing words come in over a simple write port. Address 0 holds the vertical total and the active line count, address 1 holds the blank start and end, and address 2 holds the sync start and end. Every position is written as the line at which the signal changes state, minus one.

In progressive mode the counter steps once per line. In interlaced mode it steps on both strobes, so it counts half-lines, and a field indicator alternates on each wrap. When a field holds an odd number of half-lines, consecutive fields begin on opposite halves of a line. The sync edge therefore lands mid-line in one field and at a line end in the next. Interlaced scanning has no border. A blank window that does not match the total and active counts raises a configuration error flag.

New words, and the interlace mode pin, go into a staging copy. That copy is applied only at the frame wrap, so a frame never mixes old and new timing. All outputs come from registers.

Top module: `vtiming_gen`

## Requirements
- R1: After a synchronous reset, vblank, vsync, field and cfg_err are 0 and line_cnt is 0.
- R2: In progressive mode line_cnt steps by one on each line_stb pulse. It runs 0,1,...,T, where T is the active vertical total, and the step after T gives 0.
- R3: vblank is 1 exactly while line_cnt lies in BS+1..BE. BS is the active blank start and BE the active blank end. Both change on the step leaving BS or BE respectively, and the end comparison wins when BS equals BE.
- R4: vsync follows the same rule with the sync start SS and sync end SE: it is 1 exactly while line_cnt lies in SS+1..SE.
- R5: In interlaced mode line_cnt steps on both line_stb and mid_stb, and field toggles at every wrap. In progressive mode mid_stb changes nothing, and field holds its value.
- R6: In interlaced mode with an odd half-line count T+1, vsync rises on a mid-line strobe in one field and on a line strobe in the following field, alternating from field to field.
- R7: Writes and the ilace_mode pin take effect only at the wrap step. Until then the frame in progress keeps its old total, blank, sync and mode.
- R8: cfg_err becomes 1 at the wrap that activates an interlaced configuration where BE differs from T, or BS differs from the active count plus one. Otherwise it becomes 0 at that wrap.
- R9: Word layout is the end (or total) field in wr_data[26:16] and the start (or active) field in wr_data[10:0]. Bits 31:27 and 15:11 are ignored. Address 0 holds total/active, 1 holds blank, 2 holds sync, and address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse at each line end |
| mid_stb | input | 1 | One-cycle pulse at each mid-line, used in interlaced mode |
| ilace_mode | input | 1 | 1 selects interlaced scanning (applied at wrap) |
| wr_en | input | 1 | Timing word write strobe |
| wr_addr | input | 2 | Timing word select |
| wr_data | input | 32 | Timing word |
| vblank | output | 1 | Vertical blank, registered |
| vsync | output | 1 | Vertical sync, registered |
| line_cnt | output | 11 | Current line (half-line in interlaced mode) count |
| field | output | 1 | Field indicator |
| cfg_err | output | 1 | Interlaced configuration error |

## Verification
The bench builds the block with its default 11-bit line fields and programs a 12-line progressive frame and a 13-half-line interlaced field. Frames that short allow every counter position, each blank and sync edge, and several field toggles to be swept exhaustively, with the expected level at each step computed from the programmed window arithmetic. The odd half-line field brings within reach the alternation of the sync edge between a mid-line and a line-end strobe. A mid-frame shortening of the total exposes any write that lands before the wrap.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int LW = 11;

  typedef struct packed {
    logic [LW-1:0] total;
    logic [LW-1:0] active;
    logic [LW-1:0] bst;
    logic [LW-1:0] bend;
    logic [LW-1:0] sst;
    logic [LW-1:0] send;
    logic          ilace;
  } vcfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter int HI_LSB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ilace_in,
  input  logic          load,
  output vcfg_t         act,
  output logic          cfg_err
);
  localparam int HI_MSB = HI_LSB + LW - 1;

  vcfg_t stg;
  logic [LW-1:0] hi_f, lo_f;
  logic unused_rsvd;

  assign hi_f = wr_data[HI_MSB:HI_LSB];
  assign lo_f = wr_data[LW-1:0];
  assign unused_rsvd = ^{wr_data[DW-1:HI_MSB+1], wr_data[HI_LSB-1:LW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg.ilace <= ilace_in;
      if (wr_en) begin
        case (wr_addr)
          AW'(0): begin stg.total <= hi_f; stg.active <= lo_f; end
          AW'(1): begin stg.bend  <= hi_f; stg.bst    <= lo_f; end
          AW'(2): begin stg.send  <= hi_f; stg.sst    <= lo_f; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= '0;
      cfg_err <= 1'b0;
    end else if (load) begin
      act     <= stg;
      cfg_err <= stg.ilace &&
                 ((stg.bend != stg.total) || (stg.bst != (stg.active + LW'(1))));
    end
  end

  // R7: active timing only changes on the wrap step
  a_r7_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act));
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_err));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_stb,
  input  logic          mid_stb,
  input  logic          ilace,
  input  logic [LW-1:0] total,
  output logic [LW-1:0] cnt,
  output logic          field,
  output logic          adv,
  output logic          wrap
);
  assign adv  = line_stb | (ilace & mid_stb);
  assign wrap = adv && (cnt == total);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      field <= 1'b0;
    end else if (adv) begin
      if (wrap) begin
        cnt <= '0;
        if (ilace) field <= ~field;
      end else begin
        cnt <= cnt + LW'(1);
      end
    end
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (adv && !wrap) |=> (cnt == $past(cnt) + LW'(1)));
  a_r5_field_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(field));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/vtg_edge.sv
module vtg_edge
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] start,
  input  logic [LW-1:0] stop,
  output logic          q
);
  always_ff @(posedge clk) begin
    if (rst)                        q <= 1'b0;
    else if (adv && cnt == stop)    q <= 1'b0;
    else if (adv && cnt == start)   q <= 1'b1;
  end

  // R3/R4: level changes only on a counter step
  a_r3_edge_on_step: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(cnt) == $past(start)));
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen
  import vtg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_stb,
  input  logic          mid_stb,
  input  logic          ilace_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          vblank,
  output logic          vsync,
  output logic [LW-1:0] line_cnt,
  output logic          field,
  output logic          cfg_err
);
  vcfg_t act;
  logic  adv, wrap;

  vtg_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ilace_in(ilace_mode), .load(wrap), .act(act), .cfg_err(cfg_err)
  );

  vtg_counter cnt_i (
    .clk(clk), .rst(rst), .line_stb(line_stb), .mid_stb(mid_stb),
    .ilace(act.ilace), .total(act.total), .cnt(line_cnt), .field(field),
    .adv(adv), .wrap(wrap)
  );

  vtg_edge blank_i (
    .clk(clk), .rst(rst), .adv(adv), .cnt(line_cnt),
    .start(act.bst), .stop(act.bend), .q(vblank)
  );

  vtg_edge sync_i (
    .clk(clk), .rst(rst), .adv(adv), .cnt(line_cnt),
    .start(act.sst), .stop(act.send), .q(vsync)
  );

  a_r5_prog_ignores_mid: assert property (@(posedge clk) disable iff (rst)
    (!act.ilace && mid_stb && !line_stb) |=> $stable(line_cnt));
endmodule

// File: tb/vtiming_gen_tb_top.sv
module vtiming_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_stb = 1'b0, mid_stb = 1'b0, ilace_mode = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic vblank, vsync, field, cfg_err;
  logic [10:0] line_cnt;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int rise_type [0:3];
  logic prev_sync;

  always #2 clk = ~clk;

  vtiming_gen dut_i (
    .clk(clk), .rst(rst), .line_stb(line_stb), .mid_stb(mid_stb),
    .ilace_mode(ilace_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .vsync(vsync), .line_cnt(line_cnt), .field(field),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int hi, input int lo);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a;
    wr_data = (32'(hi) << 16) | 32'(lo) | 32'hF800_F800;  // R9 reserved bits set
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit is_mid);
    @(negedge clk);
    if (is_mid) mid_stb = 1'b1; else line_stb = 1'b1;
    @(negedge clk);
    mid_stb = 1'b0; line_stb = 1'b0;
  endtask

  function automatic int inwin(input int n, input int s, input int e);
    return (n > s && n <= e) ? 1 : 0;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vblank", int'(vblank), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 line_cnt", int'(line_cnt), 0);
    chk("R1 field", int'(field), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);

    // progressive: T=11, BS=8 BE=10, SS=9 SE=10; address 3 must be ignored (R9)
    wr(2'd0, 11, 8);
    wr(2'd1, 10, 8);
    wr(2'd2, 10, 9);
    wr(2'd3, 0, 0);
    pulse(0);  // wrap from zero config, loads
    chk("R7 load wrap", int'(line_cnt), 0);
    for (int k = 1; k <= 36; k++) begin
      pulse(0);
      chk("R2 count", int'(line_cnt), k % 12);
      chk("R3 blank", int'(vblank), inwin(k % 12, 8, 10));
      chk("R4 sync", int'(vsync), inwin(k % 12, 9, 10));
      chk("R5 field prog", int'(field), 0);
    end

    // R5: mid strobe ignored in progressive mode
    pulse(1);
    chk("R5 mid ignored cnt", int'(line_cnt), 0);
    chk("R5 mid ignored blank", int'(vblank), 0);

    // R7: shorten total mid frame, old total still holds
    for (int k = 1; k <= 3; k++) pulse(0);
    wr(2'd0, 5, 8);
    for (int k = 4; k <= 11; k++) pulse(0);
    chk("R7 old total kept", int'(line_cnt), 11);
    pulse(0);
    chk("R7 wrap", int'(line_cnt), 0);
    for (int k = 1; k <= 5; k++) pulse(0);
    chk("R7 new total", int'(line_cnt), 5);
    pulse(0);
    chk("R7 new wrap", int'(line_cnt), 0);

    // interlaced: T=12 (13 half-lines), active 9, BS=10 BE=12, SS=2 SE=4
    wr(2'd0, 12, 9);
    wr(2'd1, 12, 10);
    wr(2'd2, 4, 2);
    @(negedge clk) ilace_mode = 1'b1;
    for (int k = 1; k <= 5; k++) pulse(0);
    pulse(1);  // mid still ignored: progressive active
    chk("R7 mode deferred", int'(line_cnt), 5);
    pulse(0);  // wrap, loads interlaced
    chk("R7 mode load cnt", int'(line_cnt), 0);
    chk("R5 field before", int'(field), 0);
    chk("R8 good cfg", int'(cfg_err), 0);
    prev_sync = vsync;
    for (int k = 1; k <= 52; k++) begin
      pulse((k % 2) == 0);
      chk("R5 half count", int'(line_cnt), k % 13);
      chk("R5 field", int'(field), (k / 13) % 2);
      chk("R3 ilace blank", int'(vblank), inwin(k % 13, 10, 12));
      chk("R4 ilace sync", int'(vsync), inwin(k % 13, 2, 4));
      if (vsync && !prev_sync) rise_type[k / 13] = k % 2;  // 1=line 0=mid
      prev_sync = vsync;
    end
    chk("R6 field0 rise on line", rise_type[0], 1);
    chk("R6 field1 rise on mid", rise_type[1], 0);
    chk("R6 alternation 1-2", int'(rise_type[1] != rise_type[2]), 1);
    chk("R6 alternation 2-3", int'(rise_type[2] != rise_type[3]), 1);

    // R8: bad blank end, flagged at next wrap
    wr(2'd1, 11, 10);
    for (int k = 53; k <= 64; k++) pulse((k % 2) == 0);
    chk("R8 err deferred", int'(cfg_err), 0);
    pulse(1);  // k=65, wrap
    chk("R8 err flagged", int'(cfg_err), 1);
    chk("R5 field 65", int'(field), 1);
    chk("R2 wrap 65", int'(line_cnt), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule